// File: doc/BRIEF.md
# Quadrant-Aligned Clock-Domain Word Bridge

This block moves a stream of parallel data words from a data clock domain into a converter clock domain. Each incoming word is stored in a ring of four slots, one slot per data clock edge in rotation. The converter side reads the ring at a slot given by a free-running read count plus a 2-bit offset, the quadrant. The quadrant changes only on a sync update. On an update the block either computes a quadrant that keeps the read slot two positions from the write slot, or it loads a quadrant taken from a control field. Loading a fixed quadrant lets several converter channels be aligned to one another.

A collision monitor compares the read slot with a synchronized copy of the write slot and raises a sticky alarm when the two come too close. In automatic mode the alarm starts its own update. In manual mode updates happen only on request. A register view gives one status word and one control word. When the register interface is disabled, a dedicated input takes over as the update request and a dedicated output carries the alarm. Looping that output back to that input gives automatic behaviour with no software involved.

Top module: `quad_sync`

## Requirements
- R1: The word on `dout` is the word stored in slot (read count + quadrant) mod 4, registered on `rclk`. With both clocks identical, and with a read slot sitting d = 0..3 positions ahead of the current write slot, `din` minus `dout` equals 5 - d. The value is 5 after an automatically chosen quadrant.
- R2: Reading address 0x15 returns the quadrant in bits [1:0] and the alarm in bit 2, with zeros above. Reading address 0x16 returns the control word: bit 5 external enable, bits [4:3] external quadrant, bit 2 manual enable, and zeros in bits 1, 0, 7 and 6. Any other address reads as zero.
- R3: On a computed update the quadrant becomes (synchronized write index + 2 - read count) mod 4. This puts the synchronized distance at exactly two, and the status readback shows the new value from the next cycle on.
- R4: A write to 0x16 with bit 0 set requests a sync update in every mode, automatic included. The update uses the control settings held before that write.
- R5: The alarm sets one cycle after the read slot equals the synchronized write slot or is adjacent to it. It stays set until the next update, and an update clears it.
- R6: In automatic mode (bit 2 = 0), a set alarm starts an update on the next `rclk` edge.
- R7: In manual mode (bit 2 = 1, bit 5 = 0), the quadrant changes only on a request, and the alarm stays set.
- R8: In external mode (bits 2 and 5 both 1), an update loads bits [4:3] as the quadrant. Bit 5 has no effect while bit 2 is 0.
- R9: While `reg_dis` is high, the block runs as manual with a computed quadrant. Register writes are ignored, `hw_upd` is the update request, and `hw_alarm` shows the alarm. While `reg_dis` is low, `hw_alarm` is 0.
- R10: Under reset, the quadrant, the alarm, the control word, `dout` and `hw_alarm` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Data clock |
| wrst | input | 1 | Synchronous reset, data domain |
| din | input | DW | Incoming data word |
| rclk | input | 1 | Converter clock |
| rrst | input | 1 | Synchronous reset, converter domain |
| dout | output | DW | Word delivered in the converter domain |
| reg_wr | input | 1 | Register write strobe (rclk) |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| reg_dis | input | 1 | Register interface disable, forces manual mode |
| hw_upd | input | 1 | Update request pin, active while `reg_dis` is high |
| hw_alarm | output | 1 | Alarm pin, driven while `reg_dis` is high |

## Verification
A wrong quadrant shows up at the ports as a changed distance between `din` and `dout`, two cycles after the faulty update. It also shows in bits [1:0] of 0x15 one cycle after the update. A wrong collision decision shows as a wrong alarm bit one cycle after the read slot moves. In automatic mode the same fault also shows as a quadrant that keeps changing. The bench varies the reset skew between the two domains, which moves the write phase against the read phase. For each phase it checks the computed quadrant, the loaded external quadrant, alarm persistence, and the latency that follows from each offset.

// File: rtl/qs_pkg.sv
package qs_pkg;

    localparam int QUAD_W   = 2;
    localparam int SLOTS    = 1 << QUAD_W;
    localparam int REG_W    = 8;
    localparam logic [7:0] ADDR_STATUS  = 8'h15;
    localparam logic [7:0] ADDR_CONTROL = 8'h16;
    localparam logic [QUAD_W-1:0] SAFE_GAP = 2'd2;

    typedef logic [QUAD_W-1:0] quad_t;

    typedef enum logic [1:0] {
        MODE_AUTO   = 2'd0,
        MODE_MANUAL = 2'd1,
        MODE_EXT    = 2'd2
    } mode_e;

    // control word fields, placed at bits [5:2] of the register
    typedef struct packed {
        logic  ext_en;
        quad_t ext_q;
        logic  man_en;
    } ctrl_t;

    typedef struct packed {
        logic  alarm;
        quad_t quad;
    } status_t;

    function automatic quad_t to_gray(quad_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic quad_t from_gray(quad_t g);
        return {g[1], g[1] ^ g[0]};
    endfunction

    function automatic logic too_close(quad_t rd, quad_t wr);
        quad_t gap;
        gap = rd - wr;
        return gap != SAFE_GAP;
    endfunction

endpackage

// File: rtl/qs_ring.sv
module qs_ring
    import qs_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic [DW-1:0] din,
    input  logic          rclk,
    input  logic          rrst,
    input  quad_t         rd_slot,
    output logic [DW-1:0] dout,
    output quad_t         wr_gray
);
    quad_t wptr;
    logic [SLOTS-1:0][DW-1:0] store;

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wptr    <= '0;
            wr_gray <= '0;
            store   <= '0;
        end else begin
            store[wptr] <= din;
            wptr        <= wptr + 1'b1;
            wr_gray     <= to_gray(wptr + 1'b1);
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) dout <= '0;
        else      dout <= store[rd_slot];
    end
endmodule

// File: rtl/qs_sync.sv
module qs_sync
    import qs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  quad_t d,
    output quad_t q
);
    localparam int N = (STAGES < 1) ? 1 : STAGES;
    quad_t chain [N];

    generate
        if (N == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < N; i++) chain[i] <= '0;
                end else begin
                    chain[0] <= d;
                    for (int i = 1; i < N; i++) chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[N-1];
endmodule

// File: rtl/qs_phase.sv
module qs_phase
    import qs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  quad_t ws_gray,
    input  quad_t quad,
    output quad_t rd_slot,
    output quad_t opt_q,
    output logic  collide
);
    quad_t rd_cnt;
    quad_t ws_bin;

    always_ff @(posedge clk) begin
        if (rst) rd_cnt <= '0;
        else     rd_cnt <= rd_cnt + 1'b1;
    end

    always_comb begin
        ws_bin  = from_gray(ws_gray);
        rd_slot = rd_cnt + quad;
        opt_q   = ws_bin + SAFE_GAP - rd_cnt;
        collide = too_close(rd_slot, ws_bin);
    end
endmodule

// File: rtl/qs_ctrl.sv
module qs_ctrl
    import qs_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             reg_dis,
    input  logic             hw_upd,
    output logic             hw_alarm,
    input  logic             collide,
    input  quad_t            opt_q,
    output quad_t            quad,
    output quad_t            ext_q,
    output logic             upd,
    output logic             alarm,
    output mode_e            mode
);
    ctrl_t   ctrl_q;
    status_t stat;
    logic    ctrl_hit;
    logic    req;
    quad_t   next_q;

    always_comb begin
        if (reg_dis)             mode = MODE_MANUAL;
        else if (!ctrl_q.man_en) mode = MODE_AUTO;
        else if (ctrl_q.ext_en)  mode = MODE_EXT;
        else                     mode = MODE_MANUAL;
    end

    always_comb begin
        ctrl_hit = reg_wr && !reg_dis && (reg_addr == AW'(ADDR_CONTROL));
        req      = reg_dis ? hw_upd : (ctrl_hit && reg_wdata[0]);
        upd      = req || ((mode == MODE_AUTO) && alarm);
        next_q   = (mode == MODE_EXT) ? ctrl_q.ext_q : opt_q;
        ext_q    = ctrl_q.ext_q;
        hw_alarm = reg_dis && alarm;
        stat     = '{alarm: alarm, quad: quad};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            quad   <= '0;
            alarm  <= 1'b0;
        end else begin
            if (ctrl_hit) ctrl_q <= ctrl_t'(reg_wdata[5:2]);
            if (upd) begin
                quad  <= next_q;
                alarm <= 1'b0;
            end else if (collide) begin
                alarm <= 1'b1;
            end
        end
    end

    always_comb begin
        if (reg_addr == AW'(ADDR_STATUS))
            reg_rdata = {{(REG_W-3){1'b0}}, stat};
        else if (reg_addr == AW'(ADDR_CONTROL))
            reg_rdata = {2'b00, ctrl_q, 2'b00};
        else
            reg_rdata = '0;
    end
endmodule

// File: rtl/quad_sync.sv
module quad_sync
    import qs_pkg::*;
#(
    parameter int DW          = 16,
    parameter int AW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             wclk,
    input  logic             wrst,
    input  logic [DW-1:0]    din,
    input  logic             rclk,
    input  logic             rrst,
    output logic [DW-1:0]    dout,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             reg_dis,
    input  logic             hw_upd,
    output logic             hw_alarm
);
    quad_t wr_gray, ws_gray, rd_slot, opt_q, quad, ext_q;
    logic  collide, upd, alarm;
    mode_e mode;

    qs_ring #(.DW(DW)) u_ring (
        .wclk(wclk), .wrst(wrst), .din(din),
        .rclk(rclk), .rrst(rrst), .rd_slot(rd_slot),
        .dout(dout), .wr_gray(wr_gray)
    );

    qs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(rclk), .rst(rrst), .d(wr_gray), .q(ws_gray)
    );

    qs_phase u_phase (
        .clk(rclk), .rst(rrst), .ws_gray(ws_gray), .quad(quad),
        .rd_slot(rd_slot), .opt_q(opt_q), .collide(collide)
    );

    qs_ctrl #(.AW(AW)) u_ctrl (
        .clk(rclk), .rst(rrst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_dis(reg_dis), .hw_upd(hw_upd),
        .hw_alarm(hw_alarm), .collide(collide), .opt_q(opt_q),
        .quad(quad), .ext_q(ext_q), .upd(upd), .alarm(alarm), .mode(mode)
    );
endmodule

// File: rtl/quad_sync_chk.sv
module quad_sync_chk
    import qs_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  upd,
    input logic  alarm,
    input quad_t quad,
    input quad_t opt_q,
    input quad_t ext_q,
    input mode_e mode,
    input logic  dis,
    input logic  hw_alarm
);
    // R5
    alarm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm && !upd) |=> alarm);

    // R5
    alarm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> !alarm);

    // R7
    quad_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(quad));

    // R8
    ext_load_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && mode == MODE_EXT) |=> (quad == $past(ext_q)));

    // R6
    auto_fix_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm && mode == MODE_AUTO) |=> (quad == $past(opt_q)));

    // R9
    pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !dis |-> !hw_alarm);
endmodule

bind quad_sync quad_sync_chk u_chk (
    .clk(rclk), .rst(rrst), .upd(upd), .alarm(alarm), .quad(quad),
    .opt_q(opt_q), .ext_q(ext_q), .mode(mode), .dis(reg_dis),
    .hw_alarm(hw_alarm)
);

// File: tb/sim_quad_sync.sv
module sim_quad_sync;
    localparam int DW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          wrst = 1'b1, rrst = 1'b1;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          reg_dis = 1'b0, hw_upd = 1'b0;
    logic          hw_alarm;
    logic [DW-1:0] wval;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // bench word counter, advancing exactly like a write slot rotation
    always @(posedge clk) begin
        if (wrst) wval <= '0;
        else      wval <= wval + 1'b1;
    end
    assign din = wval;

    quad_sync #(.DW(DW), .AW(AW), .SYNC_STAGES(2)) u0 (
        .wclk(clk), .wrst(wrst), .din(din), .rclk(clk), .rrst(rrst),
        .dout(dout), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_dis(reg_dis),
        .hw_upd(hw_upd), .hw_alarm(hw_alarm)
    );

    // vector: k[9:8] write skew, q[7:6] external quadrant,
    // aq[5:4] computed quadrant, al[3] alarm after load, lat[2:0]
    localparam int NV = 8;
    localparam logic [NV-1:0][9:0] VEC = {
        {2'd3, 2'd0, 2'd1, 1'b1, 3'd2},
        {2'd3, 2'd1, 2'd1, 1'b0, 3'd5},
        {2'd2, 2'd3, 2'd2, 1'b1, 3'd4},
        {2'd2, 2'd2, 2'd2, 1'b0, 3'd5},
        {2'd1, 2'd1, 2'd3, 1'b1, 3'd3},
        {2'd1, 2'd3, 2'd3, 1'b0, 3'd5},
        {2'd0, 2'd2, 2'd0, 1'b1, 3'd3},
        {2'd0, 2'd0, 2'd0, 1'b0, 3'd5}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic restart(input int k);
        @(negedge clk);
        rrst = 1'b1; wrst = 1'b1; reg_dis = 1'b0; hw_upd = 1'b0;
        tick(3);
        rrst = 1'b0;
        tick(k);
        wrst = 1'b0;
        tick(20);
    endtask

    initial begin
        logic [7:0] rd;
        tick(2);
        // R10: reset values
        reg_read(8'h15, rd); check("R10 status", rd, 0);
        reg_read(8'h16, rd); check("R10 control", rd, 0);
        check("R10 dout", dout, 0);
        check("R10 hw_alarm", hw_alarm, 0);
        reg_read(8'h20, rd); check("R2 unmapped", rd, 0);

        for (int i = 0; i < NV; i++) begin
            int k, q, aq, al, lat;
            k   = VEC[i][9:8];
            q   = VEC[i][7:6];
            aq  = VEC[i][5:4];
            al  = VEC[i][3];
            lat = VEC[i][2:0];
            restart(k);
            // R6 / R3: automatic mode settles on the computed quadrant
            reg_read(8'h15, rd);
            check("R3 auto quadrant", rd[1:0], aq);
            check("R5 auto alarm clear", rd[2], 0);
            check("R1 auto latency", 16'(din - dout), 5);
            // R8: external load
            reg_write(8'h16, 8'(8'h24 | (q << 3)));
            reg_read(8'h16, rd);
            check("R2 control readback", rd, 8'h24 | (q << 3));
            reg_write(8'h16, 8'(8'h25 | (q << 3)));
            tick(3);
            reg_read(8'h15, rd);
            check("R8 external quadrant", rd[1:0], q);
            check("R5 alarm after load", rd[2], al);
            check("R1 latency after load", 16'(din - dout), lat);
            if (i % 2 == 1) begin
                // R7: manual mode keeps quadrant and alarm
                reg_write(8'h16, 8'h04);
                tick(4);
                reg_read(8'h15, rd);
                check("R7 manual quadrant held", rd[1:0], q);
                check("R7 manual alarm held", rd[2], al);
                // R4: request computes a fresh quadrant
                reg_write(8'h16, 8'h05);
                tick(3);
                reg_read(8'h15, rd);
                check("R4 request quadrant", rd[1:0], aq);
                check("R4 request alarm", rd[2], 0);
            end else begin
                // R6: back to automatic, alarm repairs itself
                reg_write(8'h16, 8'h00);
                tick(5);
                reg_read(8'h15, rd);
                check("R6 auto repair quadrant", rd[1:0], aq);
                check("R6 auto repair alarm", rd[2], 0);
            end
        end

        // R8: external enable without manual enable has no effect
        restart(1);
        reg_write(8'h16, 8'h28);
        reg_write(8'h16, 8'h29);
        tick(3);
        reg_read(8'h15, rd);
        check("R8 ext ignored in auto", rd[1:0], 3);
        check("R4 request in auto alarm", rd[2], 0);

        // R9: register interface disabled
        restart(2);
        reg_write(8'h16, 8'h3C);
        reg_write(8'h16, 8'h3D);
        tick(3);
        reg_read(8'h15, rd);
        check("R8 ext load k2", rd[1:0], 3);
        check("R5 alarm k2", rd[2], 1);
        check("R9 pin low while enabled", hw_alarm, 0);
        reg_dis = 1'b1;
        tick(2);
        check("R9 alarm pin", hw_alarm, 1);
        reg_write(8'h16, 8'h01);
        tick(2);
        reg_read(8'h15, rd);
        check("R9 write ignored quadrant", rd[1:0], 3);
        check("R9 write ignored alarm", rd[2], 1);
        reg_read(8'h16, rd);
        check("R9 control unchanged", rd, 8'h3C);
        hw_upd = 1'b1;
        tick(1);
        hw_upd = 1'b0;
        tick(2);
        reg_read(8'h15, rd);
        check("R9 pin request quadrant", rd[1:0], 2);
        check("R9 pin request alarm", hw_alarm, 0);
        check("R1 latency after pin request", 16'(din - dout), 5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule